// File: doc/BRIEF.md
# PTP Header Locator and Field Extractor

This block watches a byte-wide Ethernet frame stream and finds where a precision-time-protocol header begins. It accepts frames carried directly over Ethernet, or inside UDP over IPv4 or IPv6, with or without one 802.1Q tag. For each frame it reports whether a complete PTP header was present. When one was, it also gives the message type, the 16-bit sequence number and a flag for peer-delay responses. A timestamping unit uses these results to pair captured times with the frames they belong to.

Bytes are qualified by `byte_valid_i`. The first byte of a frame carries `sof_i` and the last carries `eof_i`. Idle cycles inside a frame are allowed. The EtherType that marks a layer-2 PTP frame is an input; it is normally 0x88F7. The result comes out as a one-cycle strobe after the last byte of each frame. CRC and IP options are not checked.

Top module: `ptp_hdr_locator`

## Requirements
- R1: While reset is asserted and until the first frame ends, `result_valid_o`, `found_o`, `pdelay_resp_o`, `msg_type_o` and `seq_id_o` are all zero.
- R2: `result_valid_o` is high for exactly one cycle, on the clock edge after an accepted byte with `eof_i` set, and at no other time. `found_o` is high only during that strobe. A frame of a single byte (`sof_i` and `eof_i` together) is never found.
- R3: Frame byte positions count from 0 at the `sof_i` byte. When bytes 12..13 (big-endian) equal `l2_etype_i`, the PTP header starts at byte 14.
- R4: When bytes 12..13 are 0x8100, every later offset moves by 4. The EtherType is then read from bytes 16..17, and the Ethernet header ends at byte 18 instead of 14.
- R5: EtherType 0x0800 selects IPv4. The IHL is the low nibble of the first IP byte. The PTP header starts at (Ethernet end + 4*IHL + 8). The frame is rejected when IHL < 5, or when the protocol byte at IP offset 9 is not 17.
- R6: EtherType 0x86DD selects IPv6. The PTP header starts at (Ethernet end + 48). The frame is rejected unless the next-header byte at IP offset 6 is 17.
- R7: A frame is found only if it holds at least 34 bytes from the PTP header start onward. That is, its length must be at least header start + 34.
- R8: `msg_type_o` is the low nibble of PTP header byte 0. `seq_id_o` is PTP header byte 30 (high) followed by byte 31 (low).
- R9: `pdelay_resp_o` is high exactly when a frame is found and its message type is 3.
- R10: Any other EtherType gives no found flag. Every strobe without a found flag carries a message type of 0 and a sequence ID of 0.
- R11: `sof_i` restarts parsing even in the middle of a frame. Cycles with `byte_valid_i` low are ignored. Valid bytes that arrive outside a frame (no `sof_i` since the last end of frame) are ignored, including their `eof_i`, and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| l2_etype_i | input | 16 | EtherType that marks layer-2 PTP (normally 0x88F7) |
| byte_valid_i | input | 1 | Byte qualifier |
| byte_data_i | input | 8 | Frame byte |
| sof_i | input | 1 | Marks the first byte of a frame |
| eof_i | input | 1 | Marks the last byte of a frame |
| result_valid_o | output | 1 | One-cycle result strobe |
| found_o | output | 1 | A complete PTP header was located |
| msg_type_o | output | 4 | PTP message type |
| seq_id_o | output | 16 | PTP sequence ID |
| pdelay_resp_o | output | 1 | Found frame is a peer-delay response |

## Verification
Every result of this block comes from one register stage fed by the last byte of the frame. The strobe and all fields therefore become valid on the rising edge that takes in the `eof_i` byte, and they clear on the next edge. The bench drives each byte on a falling edge and reads the results at the falling edge after the last byte. It then checks, one falling edge later, that the strobe has dropped. For aborted frames and for stray bytes outside a frame, the bench watches the strobe during those cycles and for a few cycles after them.

// File: rtl/ptp_loc_pkg.sv
package ptp_loc_pkg;
  localparam int ETH_HDR_LEN  = 14;
  localparam int VLAN_LEN     = 4;
  localparam int UDP_LEN      = 8;
  localparam int IP6_LEN      = 40;
  localparam int PTP_HDR_LEN  = 34;
  localparam int SEQ_OFF      = 30;
  localparam int ET_OFF       = 12;
  localparam int IP4_PROTO_OFF = 9;
  localparam int IP6_NXT_OFF  = 6;
  localparam logic [15:0] ET_TPID = 16'h8100;
  localparam logic [15:0] ET_IP4  = 16'h0800;
  localparam logic [15:0] ET_IP6  = 16'h86DD;
  localparam logic [7:0]  PROTO_UDP = 8'd17;
  localparam logic [3:0]  MSG_PDLY_RESP = 4'd3;

  typedef enum logic [1:0] {
    ENC_NONE = 2'd0,
    ENC_L2   = 2'd1,
    ENC_IP4  = 2'd2,
    ENC_IP6  = 2'd3
  } encap_e;
endpackage

// File: rtl/ptp_frame_pos.sv
module ptp_frame_pos #(
  parameter int POS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic             take_o,   // accepted non-first byte
  output logic             start_o,  // accepted first byte
  output logic             last_o,   // accepted byte with end marker
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic             in_frame_q;
  logic [POS_W-1:0] pos_q;
  logic             acc;

  assign acc     = byte_valid_i && (sof_i || in_frame_q);
  assign start_o = byte_valid_i && sof_i;
  assign take_o  = acc && !sof_i;
  assign last_o  = acc && eof_i;
  assign pos_o   = sof_i ? '0 : pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      pos_q      <= '0;
    end else if (acc) begin
      in_frame_q <= !eof_i;
      pos_q      <= (pos_o == POS_MAX) ? POS_MAX : pos_o + 1'b1;
    end
  end
endmodule

// File: rtl/ptp_encap_decode.sv
module ptp_encap_decode
  import ptp_loc_pkg::*;
#(
  parameter int POS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             start_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       byte_i,
  input  logic [15:0]      l2_etype_i,
  output logic             hdr_vld_o,
  output logic [POS_W-1:0] hdr_off_o,
  output logic             proto_ok_o
);
  localparam logic [POS_W-1:0] P_ET_HI      = POS_W'(ET_OFF);
  localparam logic [POS_W-1:0] P_ET_HI_TAG  = POS_W'(ET_OFF + VLAN_LEN);
  localparam logic [POS_W-1:0] P_ET_LO      = POS_W'(ET_OFF + 1);
  localparam logic [POS_W-1:0] P_ET_LO_TAG  = POS_W'(ET_OFF + 1 + VLAN_LEN);
  localparam logic [POS_W-1:0] ETH_END      = POS_W'(ETH_HDR_LEN);
  localparam logic [POS_W-1:0] ETH_END_TAG  = POS_W'(ETH_HDR_LEN + VLAN_LEN);

  encap_e           kind_q;
  logic             vlan_q;
  logic [7:0]       et_hi_q;
  logic             hdr_vld_q;
  logic [POS_W-1:0] hdr_off_q;
  logic             proto_ok_q;

  logic [POS_W-1:0] eth_end;
  logic [15:0]      et_now;
  logic             at_hi, at_cls, is_tag;
  logic [POS_W-1:0] ip4_off;

  assign eth_end = vlan_q ? ETH_END_TAG : ETH_END;
  assign et_now  = {et_hi_q, byte_i};
  assign at_hi   = take_i && (pos_i == (vlan_q ? P_ET_HI_TAG : P_ET_HI));
  assign at_cls  = take_i && (pos_i == (vlan_q ? P_ET_LO_TAG : P_ET_LO));
  assign is_tag  = !vlan_q && (et_now == ET_TPID);
  assign ip4_off = eth_end + POS_W'({byte_i[3:0], 2'b00}) + POS_W'(UDP_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q     <= ENC_NONE;
      vlan_q     <= 1'b0;
      et_hi_q    <= '0;
      hdr_vld_q  <= 1'b0;
      hdr_off_q  <= '0;
      proto_ok_q <= 1'b0;
    end else if (start_i) begin
      kind_q     <= ENC_NONE;
      vlan_q     <= 1'b0;
      et_hi_q    <= '0;
      hdr_vld_q  <= 1'b0;
      hdr_off_q  <= '0;
      proto_ok_q <= 1'b0;
    end else if (take_i) begin
      if (at_hi) et_hi_q <= byte_i;
      if (at_cls && is_tag) begin
        vlan_q <= 1'b1;
      end else if (at_cls) begin
        // programmed L2 type wins over IP types
        if (et_now == l2_etype_i) begin
          kind_q     <= ENC_L2;
          hdr_vld_q  <= 1'b1;
          hdr_off_q  <= eth_end;
          proto_ok_q <= 1'b1;
        end else if (et_now == ET_IP4) begin
          kind_q <= ENC_IP4;
        end else if (et_now == ET_IP6) begin
          kind_q    <= ENC_IP6;
          hdr_vld_q <= 1'b1;
          hdr_off_q <= eth_end + POS_W'(IP6_LEN + UDP_LEN);
        end else begin
          kind_q <= ENC_NONE;
        end
      end
      if (kind_q == ENC_IP4 && pos_i == eth_end) begin
        if (byte_i[3:0] >= 4'd5) begin
          hdr_vld_q <= 1'b1;
          hdr_off_q <= ip4_off;
        end else begin
          kind_q    <= ENC_NONE;
          hdr_vld_q <= 1'b0;
        end
      end
      if (kind_q == ENC_IP4 && pos_i == eth_end + POS_W'(IP4_PROTO_OFF))
        proto_ok_q <= (byte_i == PROTO_UDP);
      if (kind_q == ENC_IP6 && pos_i == eth_end + POS_W'(IP6_NXT_OFF))
        proto_ok_q <= (byte_i == PROTO_UDP);
    end
  end

  assign hdr_vld_o  = hdr_vld_q;
  assign hdr_off_o  = hdr_off_q;
  assign proto_ok_o = proto_ok_q;
endmodule

// File: rtl/ptp_field_grab.sv
module ptp_field_grab
  import ptp_loc_pkg::*;
#(
  parameter int POS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             start_i,
  input  logic             last_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       byte_i,
  input  logic             hdr_vld_i,
  input  logic [POS_W-1:0] hdr_off_i,
  input  logic             proto_ok_i,
  output logic             result_valid_o,
  output logic             found_o,
  output logic [3:0]       msg_type_o,
  output logic [15:0]      seq_id_o,
  output logic             pdelay_resp_o
);
  localparam logic [POS_W-1:0] REL_SEQ_HI = POS_W'(SEQ_OFF);
  localparam logic [POS_W-1:0] REL_SEQ_LO = POS_W'(SEQ_OFF + 1);
  localparam logic [POS_W-1:0] REL_END    = POS_W'(PTP_HDR_LEN - 1);

  logic [3:0]       msg_q;
  logic [15:0]      seq_q;
  logic             done_q;
  logic             in_hdr, hit_end, found_n;
  logic [POS_W-1:0] rel;

  assign rel     = pos_i - hdr_off_i;
  assign in_hdr  = take_i && hdr_vld_i && (pos_i >= hdr_off_i);
  assign hit_end = in_hdr && (rel == REL_END);
  assign found_n = last_i && take_i && hdr_vld_i && proto_ok_i && (done_q || hit_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_q  <= '0;
      seq_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      msg_q  <= '0;
      seq_q  <= '0;
      done_q <= 1'b0;
    end else if (in_hdr) begin
      if (rel == '0)        msg_q       <= byte_i[3:0];
      if (rel == REL_SEQ_HI) seq_q[15:8] <= byte_i;
      if (rel == REL_SEQ_LO) seq_q[7:0]  <= byte_i;
      if (hit_end)          done_q      <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_valid_o <= 1'b0;
      found_o        <= 1'b0;
      msg_type_o     <= '0;
      seq_id_o       <= '0;
      pdelay_resp_o  <= 1'b0;
    end else begin
      result_valid_o <= last_i;
      found_o        <= found_n;
      msg_type_o     <= found_n ? msg_q : '0;
      seq_id_o       <= found_n ? seq_q : '0;
      pdelay_resp_o  <= found_n && (msg_q == MSG_PDLY_RESP);
    end
  end
endmodule

// File: rtl/ptp_hdr_locator.sv
module ptp_hdr_locator #(
  parameter int POS_W = 11
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] l2_etype_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_data_i,
  input  logic        sof_i,
  input  logic        eof_i,
  output logic        result_valid_o,
  output logic        found_o,
  output logic [3:0]  msg_type_o,
  output logic [15:0] seq_id_o,
  output logic        pdelay_resp_o
);
  logic             take, start, last;
  logic [POS_W-1:0] pos;
  logic             hdr_vld, proto_ok;
  logic [POS_W-1:0] hdr_off;

  ptp_frame_pos #(.POS_W(POS_W)) u_pos (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_valid_i),
    .sof_i        (sof_i),
    .eof_i        (eof_i),
    .take_o       (take),
    .start_o      (start),
    .last_o       (last),
    .pos_o        (pos)
  );

  ptp_encap_decode #(.POS_W(POS_W)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .start_i    (start),
    .pos_i      (pos),
    .byte_i     (byte_data_i),
    .l2_etype_i (l2_etype_i),
    .hdr_vld_o  (hdr_vld),
    .hdr_off_o  (hdr_off),
    .proto_ok_o (proto_ok)
  );

  ptp_field_grab #(.POS_W(POS_W)) u_grab (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .take_i         (take),
    .start_i        (start),
    .last_i         (last),
    .pos_i          (pos),
    .byte_i         (byte_data_i),
    .hdr_vld_i      (hdr_vld),
    .hdr_off_i      (hdr_off),
    .proto_ok_i     (proto_ok),
    .result_valid_o (result_valid_o),
    .found_o        (found_o),
    .msg_type_o     (msg_type_o),
    .seq_id_o       (seq_id_o),
    .pdelay_resp_o  (pdelay_resp_o)
  );
endmodule

// File: rtl/ptp_hdr_locator_chk.sv
module ptp_hdr_locator_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        byte_valid_i,
  input logic        sof_i,
  input logic        eof_i,
  input logic        result_valid_o,
  input logic        found_o,
  input logic [3:0]  msg_type_o,
  input logic [15:0] seq_id_o,
  input logic        pdelay_resp_o
);
  AST_STROBE_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> $past(byte_valid_i && eof_i)); // R2
  AST_FOUND_IN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> result_valid_o); // R2
  AST_ONE_BYTE_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> !$past(sof_i && eof_i)); // R2
  AST_PDELAY_ONLY_TYPE3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdelay_resp_o |-> (found_o && msg_type_o == 4'd3)); // R9
  AST_PDELAY_ON_TYPE3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && msg_type_o == 4'd3) |-> pdelay_resp_o); // R9
  AST_MISS_ZERO_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found_o |-> (msg_type_o == 4'd0 && seq_id_o == 16'd0 && !pdelay_resp_o)); // R10
endmodule

bind ptp_hdr_locator ptp_hdr_locator_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .byte_valid_i   (byte_valid_i),
  .sof_i          (sof_i),
  .eof_i          (eof_i),
  .result_valid_o (result_valid_o),
  .found_o        (found_o),
  .msg_type_o     (msg_type_o),
  .seq_id_o       (seq_id_o),
  .pdelay_resp_o  (pdelay_resp_o)
);

// File: tb/ptp_hdr_locator_tb.sv
module ptp_hdr_locator_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] l2_etype_i = 16'h88F7;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        sof_i = 1'b0;
  logic        eof_i = 1'b0;
  logic        result_valid_o, found_o, pdelay_resp_o;
  logic [3:0]  msg_type_o;
  logic [15:0] seq_id_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] fb [0:255];
  int flen;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ptp_hdr_locator dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .l2_etype_i(l2_etype_i),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .sof_i(sof_i), .eof_i(eof_i), .result_valid_o(result_valid_o),
    .found_o(found_o), .msg_type_o(msg_type_o), .seq_id_o(seq_id_o),
    .pdelay_resp_o(pdelay_resp_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // l3: 0 = layer 2, 4 = IPv4, 6 = IPv6
  task automatic build(input logic [15:0] et, input bit vlan, input int l3, input int ihl,
                       input logic [7:0] proto, input logic [3:0] msg,
                       input logic [15:0] seq, input int trim);
    int eth, off;
    for (int i = 0; i < 256; i++) fb[i] = 8'((i * 37 + 5) & 255);
    eth = vlan ? 18 : 14;
    if (vlan) begin
      fb[12] = 8'h81; fb[13] = 8'h00; fb[14] = 8'h20; fb[15] = 8'h05;
    end
    fb[eth-2] = et[15:8];
    fb[eth-1] = et[7:0];
    off = eth;
    if (l3 == 4) begin
      fb[eth] = 8'h40 | 8'(ihl);
      fb[eth+9] = proto;
      off = eth + ((ihl < 5) ? 5 : ihl) * 4 + 8;
    end else if (l3 == 6) begin
      fb[eth] = 8'h60;
      fb[eth+6] = proto;
      off = eth + 48;
    end
    fb[off] = {4'hA, msg};
    fb[off+30] = seq[15:8];
    fb[off+31] = seq[7:0];
    flen = off + 34 + trim;
  endtask

  task automatic drive_byte(input logic [7:0] d, input bit s, input bit e);
    @(negedge clk_i);
    byte_valid_i = 1'b1; byte_data_i = d; sof_i = s; eof_i = e;
  endtask

  task automatic idle();
    @(negedge clk_i);
    byte_valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0; byte_data_i = 8'hEE;
  endtask

  // sends fb[0..flen-1], then checks result at the falling edge after the last byte
  task automatic send_check(input string tag, input bit gap, input bit f,
                            input logic [3:0] m, input logic [15:0] s);
    for (int i = 0; i < flen; i++) begin
      drive_byte(fb[i], i == 0, i == flen - 1);
      if (gap && (i % 3 == 1) && i < flen - 1) idle();
    end
    idle();
    chk({tag, " R2 strobe"}, result_valid_o, 1);
    chk({tag, " found"}, found_o, f);
    chk({tag, " R8 msg"}, msg_type_o, f ? m : 4'd0);
    chk({tag, " R8 seq"}, seq_id_o, f ? s : 16'd0);
    chk({tag, " R9 pdelay"}, pdelay_resp_o, (f && m == 4'd3));
    idle();
    chk({tag, " R2 strobe drop"}, result_valid_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 valid", result_valid_o, 0);
    chk("R1 found", found_o, 0);
    chk("R1 fields", {pdelay_resp_o, msg_type_o, seq_id_o}, 0);
  endtask

  task automatic t_l2();
    build(16'h88F7, 0, 0, 0, 0, 4'd0, 16'h1234, 0);
    send_check("R3 l2 plain exact R7", 0, 1, 4'd0, 16'h1234);
    build(16'h88F7, 1, 0, 0, 0, 4'd3, 16'hBEEF, 5);
    send_check("R4 l2 vlan", 1, 1, 4'd3, 16'hBEEF);
    build(16'h88F7, 0, 0, 0, 0, 4'd1, 16'h0101, -1);
    send_check("R7 l2 short", 0, 0, 4'd1, 16'h0101);
  endtask

  task automatic t_ip4();
    build(16'h0800, 0, 4, 5, 8'd17, 4'd1, 16'h5A5A, 0);
    send_check("R5 ip4 ihl5", 0, 1, 4'd1, 16'h5A5A);
    build(16'h0800, 1, 4, 7, 8'd17, 4'd3, 16'hC001, 2);
    send_check("R5 R4 ip4 opts vlan", 1, 1, 4'd3, 16'hC001);
    build(16'h0800, 0, 4, 5, 8'd6, 4'd1, 16'h7777, 0);
    send_check("R5 ip4 tcp", 0, 0, 4'd1, 16'h7777);
    build(16'h0800, 0, 4, 4, 8'd17, 4'd1, 16'h7778, 0);
    send_check("R5 ip4 ihl4", 0, 0, 4'd1, 16'h7778);
    build(16'h0800, 0, 4, 6, 8'd17, 4'd2, 16'h1357, -1);
    send_check("R7 R5 ip4 short", 0, 0, 4'd2, 16'h1357);
  endtask

  task automatic t_ip6();
    build(16'h86DD, 0, 6, 0, 8'd17, 4'd2, 16'hFACE, 0);
    send_check("R6 ip6 udp", 0, 1, 4'd2, 16'hFACE);
    build(16'h86DD, 1, 6, 0, 8'd17, 4'd3, 16'h0042, 1);
    send_check("R6 R4 ip6 vlan", 1, 1, 4'd3, 16'h0042);
    build(16'h86DD, 0, 6, 0, 8'd58, 4'd2, 16'hFACE, 0);
    send_check("R6 ip6 not udp", 0, 0, 4'd2, 16'hFACE);
  endtask

  task automatic t_etype();
    build(16'h1234, 0, 0, 0, 0, 4'd0, 16'h9999, 4);
    send_check("R10 unknown etype", 0, 0, 4'd0, 16'h9999);
    l2_etype_i = 16'h9000;
    build(16'h9000, 0, 0, 0, 0, 4'd3, 16'h2468, 0);
    send_check("R3 programmed etype", 0, 1, 4'd3, 16'h2468);
    build(16'h88F7, 0, 0, 0, 0, 4'd3, 16'h2469, 0);
    send_check("R3 old etype ignored", 0, 0, 4'd3, 16'h2469);
    l2_etype_i = 16'h88F7;
  endtask

  task automatic t_restart();
    int seen;
    // one-byte frame
    drive_byte(8'h11, 1, 1);
    idle();
    chk("R2 one byte strobe", result_valid_o, 1);
    chk("R2 one byte not found", found_o, 0);
    // aborted frame: no end marker, then a new start
    build(16'h88F7, 0, 0, 0, 0, 4'd3, 16'h0F0F, 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      drive_byte(fb[i], i == 0, 0);
      if (result_valid_o) seen++;
    end
    build(16'h86DD, 0, 6, 0, 8'd17, 4'd5, 16'hABCD, 0);
    send_check("R11 restart", 1, 1, 4'd5, 16'hABCD);
    // stray bytes outside a frame, last one with end marker
    drive_byte(8'h88, 0, 0);
    drive_byte(8'hF7, 0, 0);
    drive_byte(8'h03, 0, 1);
    idle();
    if (result_valid_o) seen++;
    idle();
    if (result_valid_o) seen++;
    chk("R11 no strobe outside frame", seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_l2();
    t_ip4();
    t_ip6();
    t_etype();
    t_restart();
    repeat (3) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule